// File: doc/BRIEF.md
# Universal Shift Register with Shared Three-State Parallel Port

This block is a parameterised register, eight bits wide by default, that can hold its value, shift toward the high end, shift toward the low end, or capture a parallel word on each rising clock edge. Each end of the register has its own serial input. One parallel port does two jobs: it is the load input and it is the readback output. The port is presented as three synthesizable buses: an input bus, an output bus and a per-bit drive enable. The surrounding logic resolves these into a real bidirectional pad or bus.

Two select inputs pick the operation. Two active-low enables gate the port drivers. Choosing the load operation always releases the port, whatever the enables say, so that an external agent can put the word to be captured onto the port. Two serial taps always show the end bits of the register, so chains of these registers can be cascaded while the parallel port is released. A synchronous active-low reset clears the register and takes priority over every other input.

Top module: `ushift8_port`

## Requirements
- R1: When rst_n is sampled low at a rising edge, the register becomes all zeros after that edge, whatever the select, serial and port inputs are.
- R2: With sel_rt=0 and sel_lf=0 (hold), the register keeps its value across the edge.
- R3: With sel_rt=1 and sel_lf=0 (shift toward the high end), ser_lo enters bit 0 and each bit i moves to bit i+1. The old top bit is discarded.
- R4: With sel_rt=0 and sel_lf=1 (shift toward the low end), ser_hi enters the top bit and each bit i moves to bit i-1. The old bit 0 is discarded.
- R5: With sel_rt=1 and sel_lf=1 (load), the register captures port_in at the edge.
- R6: port_drv is all ones when oe_a_n=0, oe_b_n=0 and the operation is not load. In every other case it is all zeros. port_out always carries the register contents.
- R7: While the load operation is selected, port_drv is all zeros even when both enables are low. The resolved port therefore carries the externally applied word.
- R8: tap_lo always equals register bit 0 and tap_hi always equals the top bit, independent of the output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear, top priority |
| sel_rt | input | 1 | Operation select, high-end shift term |
| sel_lf | input | 1 | Operation select, low-end shift term |
| oe_a_n | input | 1 | Active-low port enable A |
| oe_b_n | input | 1 | Active-low port enable B |
| ser_lo | input | 1 | Serial data entering bit 0 |
| ser_hi | input | 1 | Serial data entering the top bit |
| port_in | input | WIDTH | Parallel port, inbound direction |
| port_out | output | WIDTH | Parallel port, outbound data (register contents) |
| port_drv | output | WIDTH | Per-bit drive enable for the parallel port |
| tap_lo | output | 1 | Register bit 0 |
| tap_hi | output | 1 | Register top bit |

## Verification
The register responds to the inputs sampled at a rising edge, so port_out and both taps show the new contents right after that edge. port_drv, by contrast, follows the select and enable inputs with no register in between, in the same cycle. The bench changes its inputs on the falling edge and queues one expected item for each edge. Its monitor compares data, taps, drive enables and the resolved port 1 ns after the rising edge, while those inputs are still applied. At that moment the register has been updated and the combinational drive enable reflects the inputs of the same step.

// File: rtl/ushr_pkg.sv
// Package: shared operation type for the universal shift register.
// Assumes: selects are decoded to exactly one of four operations.
package ushr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_SHR  = 2'd1,
        OP_SHL  = 2'd2,
        OP_LOAD = 2'd3
    } ushr_op_t;
endpackage

// File: rtl/ushr_mode_dec.sv
// Module: decodes the two select lines into an operation and a load flag.
// Assumes: purely combinational; the selects are synchronous to the clock.
module ushr_mode_dec
    import ushr_pkg::*;
(
    input  logic     sel_rt,
    input  logic     sel_lf,
    output ushr_op_t op,
    output logic     is_load
);
    // Map the select pair onto the operation enumeration.
    always_comb begin
        unique case ({sel_lf, sel_rt})
            2'b00:   op = OP_HOLD;
            2'b01:   op = OP_SHR;
            2'b10:   op = OP_SHL;
            default: op = OP_LOAD;
        endcase
        is_load = (op == OP_LOAD);
    end
endmodule

// File: rtl/ushr_core.sv
// Module: storage register performing hold, both shifts and parallel capture.
// Assumes: WIDTH >= 2; reset is synchronous, active low and overrides the operation.
module ushr_core
    import ushr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ushr_op_t         op,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    // Update the register once per rising edge, reset first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_HOLD: q <= q;
                OP_SHR:  q <= {q[TOP-1:0], ser_lo};
                OP_SHL:  q <= {ser_hi, q[TOP:1]};
                default: q <= par_in;
            endcase
        end
    end
endmodule

// File: rtl/ushr_port_ctl.sv
// Module: per-bit drive enables for the shared parallel port.
// Assumes: both enables active low; a load request always releases the port.
module ushr_port_ctl #(
    parameter int WIDTH = 8
) (
    input  logic             is_load,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    output logic [WIDTH-1:0] drv
);
    logic drive_ok;

    // Decide whether the port may be driven in this cycle.
    always_comb drive_ok = !oe_a_n && !oe_b_n && !is_load;

    // Fan the decision out to one enable per port bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_drv
        assign drv[i] = drive_ok;
    end
endmodule

// File: rtl/ushift8_port.sv
// Module: top of the universal shift register with a shared three-state port.
// Assumes: external logic resolves port_out/port_drv/port_in into one pad bus.
module ushift8_port
    import ushr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_rt,
    input  logic             sel_lf,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] port_in,
    output logic [WIDTH-1:0] port_out,
    output logic [WIDTH-1:0] port_drv,
    output logic             tap_lo,
    output logic             tap_hi
);
    ushr_op_t         op;
    logic             is_load;
    logic [WIDTH-1:0] q;

    ushr_mode_dec u_dec (
        .sel_rt (sel_rt),
        .sel_lf (sel_lf),
        .op     (op),
        .is_load(is_load)
    );

    ushr_core #(.WIDTH(WIDTH)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .ser_lo(ser_lo),
        .ser_hi(ser_hi),
        .par_in(port_in),
        .q     (q)
    );

    ushr_port_ctl #(.WIDTH(WIDTH)) u_port (
        .is_load(is_load),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .drv    (port_drv)
    );

    // Present the register on the outbound bus and on both end taps.
    always_comb begin
        port_out = q;
        tap_lo   = q[0];
        tap_hi   = q[WIDTH-1];
    end
endmodule

// File: rtl/ushr_checker.sv
// Module: protocol checker bound to the top; observes ports only.
// Assumes: the same WIDTH as the bound instance.
module ushr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_rt,
    input logic             sel_lf,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic             ser_lo,
    input logic             ser_hi,
    input logic [WIDTH-1:0] port_in,
    input logic [WIDTH-1:0] port_out,
    input logic [WIDTH-1:0] port_drv,
    input logic             tap_lo,
    input logic             tap_hi
);
    logic armed = 1'b0;

    // Mark that at least one edge has passed, so history is meaningful.
    always_ff @(posedge clk) armed <= 1'b1;

    p_reset_r1: assert property (@(posedge clk) disable iff (!armed)
        !rst_n |=> port_out == '0);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_rt && !sel_lf) |=> $stable(port_out));

    p_shr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rt && !sel_lf) |=> port_out == {$past(port_out[WIDTH-2:0]), $past(ser_lo)});

    p_shl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_rt && sel_lf) |=> port_out == {$past(ser_hi), $past(port_out[WIDTH-1:1])});

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rt && sel_lf) |=> port_out == $past(port_in));

    p_drv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> port_drv == '0);

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rt && sel_lf) |-> port_drv == '0);

    p_tap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rt && !sel_lf) |=> tap_hi == $past(port_out[WIDTH-2]));
endmodule

bind ushift8_port ushr_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_ushift8_port.sv
module sim_ushift8_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_rt = 1'b0, sel_lf = 1'b0;
    logic         oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic         ser_lo = 1'b0, ser_hi = 1'b0;
    logic [W-1:0] ext_data = '0;
    logic [W-1:0] port_bus, port_out, port_drv;
    logic         tap_lo, tap_hi;

    typedef struct {
        logic [W-1:0] data;
        logic [W-1:0] drv;
        logic [W-1:0] bus;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    logic [W-1:0] model = '0;
    int           n_chk = 0, n_fail = 0;
    bit           done = 0;

    always #2.5 clk = ~clk;

    // Resolve the three port buses plus the external agent into one bus.
    for (genvar i = 0; i < W; i++) begin : g_bus
        assign port_bus[i] = port_drv[i] ? port_out[i] : ext_data[i];
    end

    ushift8_port #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_rt(sel_rt), .sel_lf(sel_lf),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_lo(ser_lo), .ser_hi(ser_hi),
        .port_in(port_bus), .port_out(port_out), .port_drv(port_drv),
        .tap_lo(tap_lo), .tap_hi(tap_hi)
    );

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic step(input logic rs, input logic srt, input logic slf,
                        input logic oa, input logic ob, input logic sl,
                        input logic sh, input logic [W-1:0] ext, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rs; sel_rt = srt; sel_lf = slf; oe_a_n = oa; oe_b_n = ob;
        ser_lo = sl; ser_hi = sh; ext_data = ext;
        if (!rs) model = '0;
        else case ({slf, srt})
            2'b00: model = model;
            2'b01: model = {model[W-2:0], sl};
            2'b10: model = {sh, model[W-1:1]};
            default: model = ext;
        endcase
        e.data = model;
        e.drv  = (!oa && !ob && !(srt && slf)) ? '1 : '0;
        e.bus  = (e.drv[0]) ? model : ext;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (port_out !== e.data || port_drv !== e.drv || port_bus !== e.bus ||
                tap_lo !== e.data[0] || tap_hi !== e.data[W-1]) begin
                n_fail++;
                $display("FAIL %s: out=%h drv=%h bus=%h taps=%b%b exp out=%h drv=%h bus=%h taps=%b%b",
                         e.tag, port_out, port_drv, port_bus, tap_hi, tap_lo,
                         e.data, e.drv, e.bus, e.data[W-1], e.data[0]);
            end
        end
    end

    initial begin
        // R1 reset state
        step(0, 0, 0, 1, 1, 0, 0, 8'h00, "R1 reset");
        step(0, 1, 1, 0, 0, 0, 0, 8'hFF, "R1 reset over load");
        // R5 load with enables off; R6 port released
        step(1, 1, 1, 1, 1, 0, 0, 8'hA5, "R5 load A5");
        // R2 hold with port driven (R6)
        step(1, 0, 0, 0, 0, 1, 1, 8'h00, "R2 hold driven R6");
        step(1, 0, 0, 1, 0, 1, 1, 8'h3C, "R6 enable A off");
        step(1, 0, 0, 0, 1, 0, 0, 8'h3C, "R6 enable B off");
        // R7 load with both enables on still releases port
        step(1, 1, 1, 0, 0, 0, 0, 8'h3C, "R7 load with oe on");
        step(1, 0, 0, 0, 0, 0, 0, 8'h00, "R7 readback");
        // R3 eight shifts toward the high end
        for (int i = 0; i < 8; i++)
            step(1, 1, 0, 0, 0, logic'((8'b1101_0011 >> i) & 1), 0, 8'h00, "R3 shift high");
        // R4 eight shifts toward the low end, enables off, taps checked (R8)
        for (int i = 0; i < 8; i++)
            step(1, 0, 1, 1, 1, 0, logic'((8'b0110_1001 >> i) & 1), 8'h00, "R4 shift low R8");
        // R8 taps with port released
        step(1, 1, 1, 1, 1, 0, 0, 8'h81, "R8 load 81");
        step(1, 0, 0, 1, 1, 0, 0, 8'h00, "R8 taps released");
        // R1 reset over shifting
        step(1, 1, 1, 1, 1, 0, 0, 8'hFF, "R5 load FF");
        step(0, 1, 0, 0, 0, 1, 1, 8'h00, "R1 reset over shift");
        step(1, 0, 1, 0, 0, 0, 1, 8'h00, "R4 shift after reset");
        step(1, 0, 0, 0, 0, 0, 0, 8'h00, "R2 final hold");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule